// File: doc/BRIEF.md
# Stack CPU Load/Store Address Generator

This block decodes one memory-access instruction of a 16-bit, byte-addressed, little-endian stack processor. From the opcode and the current instruction pointer, data-stack pointer, top and second stack items and I/O-enable bit, it forms the effective address and the access attributes: size, direction, whether the access goes to I/O space, how many data-stack items the instruction consumes, which stack item supplies store data, and whether a word access is misaligned.

All results are registered. They appear one clock after a strobed opcode. The block also drives two byte lanes toward memory: per-lane write enables and replicated write data for stores. For loads it combines the two read lanes into a stack word. A loaded byte is zero-extended, and a loaded word is built with the even-address byte in the low half.

The sequencer that owns bus timing and moves the stack pointers reads these outputs. It uses `ag_pop` and `ag_data_nos` to update the stack.

Top module: `lsagen`

## Requirements
- R1: `ag_valid` is 1 exactly one clock after a cycle with `op_valid`=1 and an opcode with bit 15=0, bit 2=1 and bit 0=1. Otherwise it is 0, and it is 0 after reset.
- R2: Opcode bit 12 selects a word access (1) or a byte access (0). Opcode bit 1 selects a store (1) or a load (0). These bits drive `ag_word` and `ag_write`.
- R3: Opcode bits 14:13 pick the base: 00 = zero, 01 = DSP, 10 = instruction base, 11 = TOS. The 9-bit displacement in bits 11:3 is zero-extended for bases 00 and 01 and sign-extended for 10 and 11. The address is base plus displacement, modulo 2^16.
- R4: For word accesses the extended displacement is shifted left one bit before it is added.
- R5: The instruction base is `ip`+2.
- R6: `ag_pop` counts the data-stack items consumed. It is 0 for a load with a base other than TOS, and 1 for a TOS-based load or for a store with a base other than TOS. It is 2 for a TOS-based store, which alone sets `ag_data_nos` and takes its data from `nos`. Every other store takes its data from `tos`.
- R7: `ag_io` is 1 only when `io_en` is 1, the base is zero or TOS, and the address lies in 0x0200..0x03FF. DSP- and instruction-based accesses never select I/O.
- R8: A word access to an odd address sets `ag_misalign` and drives `ag_be`=00.
- R9: In a store, the byte enables are bit 0 for the even lane and bit 1 for the odd lane. A word store sets 11 and drives the data with its low byte on the even lane. A byte store enables only the lane given by address bit 0 and puts the data's low byte on both lanes. Loads and idle cycles drive `ag_be`=00.
- R10: `ld_value` is {`rd_odd`,`rd_even`} for a word load. For a byte load it is the lane chosen by address bit 0, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 16 | Instruction word |
| ip | input | 16 | Address of the current instruction |
| dsp | input | 16 | Data-stack pointer |
| tos | input | 16 | Top stack item |
| nos | input | 16 | Second stack item |
| io_en | input | 1 | I/O-enable status bit |
| rd_even | input | 8 | Read byte from the even lane |
| rd_odd | input | 8 | Read byte from the odd lane |
| ag_valid | output | 1 | Registered results valid |
| ag_addr | output | 16 | Effective byte address |
| ag_word | output | 1 | Word (1) or byte (0) access |
| ag_write | output | 1 | Store (1) or load (0) |
| ag_io | output | 1 | Access targets I/O space |
| ag_misalign | output | 1 | Illegal odd word access |
| ag_data_nos | output | 1 | Store data comes from NOS |
| ag_pop | output | 2 | Data-stack items consumed |
| ag_be | output | 2 | Lane write enables |
| ag_wdata | output | 16 | Write data, odd lane in bits 15:8 |
| ld_value | output | 16 | Assembled load result |

## Verification
The address, attribute, pop, enable and write-data outputs all pass through one register stage. They are due on the clock edge after the strobe. `ld_value` is combinational from the registered address and size and the read lanes, so it follows a lane change in the same cycle.

Each scenario drives its inputs on a falling edge and lets one rising edge capture them. It checks the outputs on the next falling edge. For load assembly it changes the lanes and waits a short delay before sampling, with no further clock edge.

// File: rtl/lsagen.sv
module lsagen #(
  parameter int          AW       = 16,
  parameter logic [AW-1:0] IO_LO  = 16'h0200,
  parameter logic [AW-1:0] IO_HI  = 16'h03FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [15:0]   opcode,
  input  logic [AW-1:0] ip,
  input  logic [AW-1:0] dsp,
  input  logic [15:0]   tos,
  input  logic [15:0]   nos,
  input  logic          io_en,
  input  logic [7:0]    rd_even,
  input  logic [7:0]    rd_odd,
  output logic          ag_valid,
  output logic [AW-1:0] ag_addr,
  output logic          ag_word,
  output logic          ag_write,
  output logic          ag_io,
  output logic          ag_misalign,
  output logic          ag_data_nos,
  output logic [1:0]    ag_pop,
  output logic [1:0]    ag_be,
  output logic [15:0]   ag_wdata,
  output logic [15:0]   ld_value
);
  localparam logic [1:0] B_ZERO = 2'b00, B_DSP = 2'b01, B_INSN = 2'b10, B_TOS = 2'b11;

  logic          hit;
  logic [1:0]    base_sel;
  logic          is_word, is_store;
  logic [8:0]    disp;
  logic [AW-1:0] ext, off, base, addr;
  logic          io_ok;
  logic [1:0]    base_q;

  assign hit      = op_valid & ~opcode[15] & opcode[2] & opcode[0];
  assign base_sel = opcode[14:13];
  assign is_word  = opcode[12];
  assign is_store = opcode[1];
  assign disp     = opcode[11:3];
  assign ext      = base_sel[1] ? {{(AW-9){disp[8]}}, disp} : {{(AW-9){1'b0}}, disp};
  assign off      = is_word ? {ext[AW-2:0], 1'b0} : ext;

  always_comb begin
    case (base_sel)
      B_ZERO:  base = '0;
      B_DSP:   base = dsp;
      B_INSN:  base = ip + AW'(2);
      default: base = tos;
    endcase
  end

  assign addr  = base + off;
  assign io_ok = io_en & (base_sel == B_ZERO || base_sel == B_TOS)
               & (addr >= IO_LO) & (addr <= IO_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ag_valid    <= 1'b0;
      ag_addr     <= '0;
      ag_word     <= 1'b0;
      ag_write    <= 1'b0;
      ag_io       <= 1'b0;
      ag_misalign <= 1'b0;
      ag_data_nos <= 1'b0;
      ag_pop      <= 2'd0;
      ag_wdata    <= '0;
      base_q      <= B_ZERO;
    end else begin
      ag_valid <= hit;
      if (hit) begin
        ag_addr     <= addr;
        ag_word     <= is_word;
        ag_write    <= is_store;
        ag_io       <= io_ok;
        ag_misalign <= is_word & addr[0];
        ag_data_nos <= is_store & (base_sel == B_TOS);
        ag_pop      <= 2'(is_store) + 2'(base_sel == B_TOS);
        base_q      <= base_sel;
        if (is_store) begin
          if (base_sel == B_TOS) ag_wdata <= is_word ? nos : {nos[7:0], nos[7:0]};
          else                   ag_wdata <= is_word ? tos : {tos[7:0], tos[7:0]};
        end
      end
    end
  end

  always_comb begin
    ag_be = 2'b00;
    if (ag_valid && ag_write && !ag_misalign)
      ag_be = ag_word ? 2'b11 : (ag_addr[0] ? 2'b10 : 2'b01);
  end

  assign ld_value = ag_word ? {rd_odd, rd_even}
                            : {8'h00, (ag_addr[0] ? rd_odd : rd_even)};

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ag_valid |-> $past(op_valid));
  assert_misalign_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ag_valid && ag_misalign) |-> (ag_word && ag_addr[0] && ag_be == 2'b00));
  assert_io_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ag_valid && ag_io) |-> (ag_addr >= IO_LO && ag_addr <= IO_HI
                             && base_q != B_DSP && base_q != B_INSN));
  assert_nos_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ag_valid && ag_data_nos) |-> (ag_write && ag_pop == 2'd2));
  assert_pop_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ag_valid |-> (ag_pop != 2'd3));
  assert_load_no_be_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ag_valid || !ag_write) |-> (ag_be == 2'b00));
endmodule

// File: tb/lsagen_tb.sv
module lsagen_tb_top;
  logic clk = 0, rst_n = 0, op_valid = 0, io_en = 0;
  logic [15:0] opcode = 0, ip = 0, dsp = 0, tos = 0, nos = 0;
  logic [7:0] rd_even = 0, rd_odd = 0;
  logic ag_valid, ag_word, ag_write, ag_io, ag_misalign, ag_data_nos;
  logic [15:0] ag_addr, ag_wdata, ld_value;
  logic [1:0] ag_pop, ag_be;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  lsagen dut_i (.clk, .rst_n, .op_valid, .opcode, .ip, .dsp, .tos, .nos, .io_en,
    .rd_even, .rd_odd, .ag_valid, .ag_addr, .ag_word, .ag_write, .ag_io,
    .ag_misalign, .ag_data_nos, .ag_pop, .ag_be, .ag_wdata, .ld_value);

  function automatic logic [15:0] mk(input logic [1:0] m, input logic w, input logic s,
                                     input logic [8:0] d);
    return {1'b0, m, w, d, 1'b1, s, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] op, input logic [15:0] i_ip, i_dsp, i_tos,
                       i_nos, input logic i_io);
    @(negedge clk);
    opcode = op; ip = i_ip; dsp = i_dsp; tos = i_tos; nos = i_nos; io_en = i_io;
    op_valid = 1;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset valid", 16'(ag_valid), 16'h0);
    chk("R9 reset be", 16'(ag_be), 16'h0);
  endtask

  task automatic t_zero;
    issue(mk(2'b00, 0, 0, 9'h1FF), 0, 0, 0, 0, 1);
    chk("R1 valid", 16'(ag_valid), 1);
    chk("R3 zero byte addr", ag_addr, 16'h01FF);
    chk("R2 byte load", {14'h0, ag_word, ag_write}, 0);
    chk("R7 below window", 16'(ag_io), 0);
    chk("R6 pop load", 16'(ag_pop), 0);
    issue(mk(2'b00, 1, 0, 9'h1FF), 0, 0, 0, 0, 1);
    chk("R4 word scale", ag_addr, 16'h03FE);
    chk("R7 zero io", 16'(ag_io), 1);
    issue(mk(2'b00, 1, 0, 9'h100), 0, 0, 0, 0, 0);
    chk("R7 io_en clear", 16'(ag_io), 0);
  endtask

  task automatic t_dsp;
    issue(mk(2'b01, 1, 1, 9'h005), 0, 16'h8000, 16'hCAFE, 0, 0);
    chk("R3 dsp addr", ag_addr, 16'h800A);
    chk("R2 word store", {14'h0, ag_word, ag_write}, 3);
    chk("R6 pop store", 16'(ag_pop), 1);
    chk("R9 word be", 16'(ag_be), 3);
    chk("R9 word data", ag_wdata, 16'hCAFE);
    chk("R6 tos source", 16'(ag_data_nos), 0);
    issue(mk(2'b01, 0, 0, 9'h002), 0, 16'h0200, 0, 0, 1);
    chk("R3 dsp byte", ag_addr, 16'h0202);
    chk("R7 dsp never io", 16'(ag_io), 0);
  endtask

  task automatic t_insn;
    issue(mk(2'b10, 0, 0, 9'h1FF), 16'h1000, 0, 0, 0, 0);
    chk("R5 ip+2 minus 1", ag_addr, 16'h1001);
    rd_even = 8'h11; rd_odd = 8'hAB; #1;
    chk("R10 byte odd lane", ld_value, 16'h00AB);
    issue(mk(2'b10, 1, 0, 9'h1FE), 16'h0300, 0, 0, 0, 1);
    chk("R4 signed word", ag_addr, 16'h02FE);
    chk("R7 insn never io", 16'(ag_io), 0);
    rd_even = 8'h34; rd_odd = 8'h12; #1;
    chk("R10 word assembly", ld_value, 16'h1234);
  endtask

  task automatic t_tos;
    issue(mk(2'b11, 0, 1, 9'h003), 0, 0, 16'h0201, 16'hBEEF, 1);
    chk("R3 tos addr", ag_addr, 16'h0204);
    chk("R7 tos io", 16'(ag_io), 1);
    chk("R6 pop two", 16'(ag_pop), 2);
    chk("R6 nos source", 16'(ag_data_nos), 1);
    chk("R9 byte be even", 16'(ag_be), 1);
    chk("R9 byte data", ag_wdata, 16'hEFEF);
    issue(mk(2'b11, 1, 0, 9'h0FF), 0, 0, 16'h1000, 0, 0);
    chk("R4 signed max", ag_addr, 16'h11FE);
    chk("R6 tos load pop", 16'(ag_pop), 1);
    rd_even = 8'h5A; rd_odd = 8'hC3; #1;
    chk("R10 word load", ld_value, 16'hC35A);
  endtask

  task automatic t_edges;
    issue(mk(2'b11, 1, 0, 9'h000), 0, 0, 16'h1001, 0, 0);
    chk("R8 misalign load", 16'(ag_misalign), 1);
    issue(mk(2'b11, 1, 1, 9'h000), 0, 0, 16'h1001, 16'h1234, 0);
    chk("R8 misalign store flag", 16'(ag_misalign), 1);
    chk("R8 misalign no be", 16'(ag_be), 0);
    issue(mk(2'b00, 0, 1, 9'h007), 0, 0, 16'h9A77, 0, 0);
    chk("R9 byte odd be", 16'(ag_be), 2);
    chk("R9 byte odd data", ag_wdata, 16'h7777);
    chk("R8 byte never misalign", 16'(ag_misalign), 0);
    rd_even = 8'h44; rd_odd = 8'h99; #1;
    chk("R10 zero extend", ld_value, 16'h0099);
    issue(16'h8005, 0, 0, 0, 0, 0);
    chk("R1 foreign opcode", 16'(ag_valid), 0);
    issue(mk(2'b00, 0, 0, 9'h0) & 16'hFFFB, 0, 0, 0, 0, 0);
    chk("R1 bit2 clear", 16'(ag_valid), 0);
    @(negedge clk);
    chk("R1 no strobe", 16'(ag_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 t_reset();
    t_zero();
    t_dsp();
    t_insn();
    t_tos();
    t_edges();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule